// File: doc/BRIEF.md
# Parallel NOR Flash Command Front End

This block sits between a simple synchronous host bus and a small on-chip byte array. It gives the array the command behaviour of a parallel NOR flash. The host writes command codes on the data bus. Depending on the code and on how far a multi-write sequence has got, the block does one of the following: programs a word, erases one sector, collects a counted burst of buffered writes, accepts a lock or unlock pair, or switches the meaning of reads.

A read returns one of four things, chosen by the current mode:
- array data;
- the 8-bit status register;
- a pair of identifier half-words;
- a byte of a computed query table.

The bus is `BUS_BYTES` wide (1, 2 or 4). A static pin selects the byte order used for array reads and writes. A second static pin makes the array read-only. In that case programs and erases leave the array untouched and set error bits in the status register.

Software drives the block with plain bus writes. The command code is always the low data byte. For a read, software raises the read strobe and picks up the result one clock later.

Top module: `pnor_cmd_if`

## Requirements
- R1: In the idle write state, a command byte of 0x00, 0xF0 or 0xFF, or any code not listed in these requirements, selects array-read mode and drops any pending command.
- R2: Code 0x10 or 0x40 arms a program. The next write stores its data word at its address and returns the block to array-read mode. The status register holds ready at bit 7 and program error at bit 4. Bit 7 is set after the program write. When the read-only pin is high, bit 4 is set and the array is left unchanged.
- R3: Code 0x20 fills the whole sector that holds the address with 0xFF and sets status bit 7. Other sectors are untouched. When the array is read-only, status bit 5 (erase error) is set and nothing is erased.
- R4: The write that follows 0x20 is checked. A value of 0xD0 completes the erase and sets bit 7, and reads then keep returning status. A value of 0xFF, or any other value, selects array-read mode.
- R5: Code 0x50 clears all eight status bits and selects array-read mode. Code 0x70 selects status reads. Status reads also apply while an erase, lock or buffered write is pending or confirmed. A status read returns the register in the low 8 bits, with the upper bits at zero.
- R6: After code 0x90, a read computes an index: the low address byte shifted right by log2(`BUS_BYTES`). Index 0 returns {`ID_W0`,`ID_W1`}, index 1 returns {`ID_W2`,`ID_W3`}, and any other index returns 0. Each value is truncated to the bus width.
- R7: After code 0x98, reads use the same index to return a query byte. The bytes are:
  - 0x10/0x11/0x12 hold 0x51/0x52/0x59;
  - 0x13 holds 0x01;
  - 0x27 holds log2 of the array size;
  - 0x2C holds 0x01;
  - 0x2D holds `NUM_SECT`-1;
  - every other index holds 0, including every index at or above `QRY_LEN`.

  Only a write of 0xFF leaves query mode.
- R8: Code 0xE8 sets status bit 7 and starts a buffered write. The next write gives a count N in its low byte, and N+1 data writes follow. Each data write is stored, sets bit 7, and sets bit 4 instead of storing when the array is read-only. After the last data write, 0xD0 confirms and sets bit 7. Any other value selects array-read mode; the words already written remain in the array.
- R9: Code 0x60 waits for one more write. A value of 0xD0 or 0x01 completes it and sets bit 7, and status reads follow. Any other value selects array-read mode.
- R10: Array reads and data writes of `BUS_BYTES` bytes use the bytes at address, address+1, and so on, wrapping at the top of the array. With the byte-order pin high, the byte at the address is the most significant byte. With the pin low, it is the least significant byte.
- R11: A synchronous active-low reset clears the status register, the read output and the command state to array-read idle. The array contents are kept.
- R12: The read result appears on `rdata_o` one clock after the read strobe and holds until the next read. The two strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| big_end_i | input | 1 | Static byte order: 1 = first byte most significant |
| wr_prot_i | input | 1 | Static read-only condition for the array |
| addr_i | input | log2(NUM_SECT*SECT_BYTES) | Byte address |
| wdata_i | input | 8*BUS_BYTES | Write data; command code in the low byte |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8*BUS_BYTES | Read result, registered |

## Verification
A wrong command state shows up at the ports on the very next read. The read path changes meaning with the mode, so a status value appears where array data was expected, or the reverse, one clock after the strobe. A wrong write phase, such as a miscounted buffer or a lost confirm step, may stay hidden for several writes. It shows only when a later confirm or abort leaves the wrong mode or the wrong bytes behind. For that reason the sequences read back both the status register and the array right after each step. A corrupted error bit can stay hidden until the next status read.

// File: rtl/pnor_pkg.sv
// Shared command codes, status bit positions and write-phase type for the
// parallel NOR command front end. Assumes the command is the low data byte.
package pnor_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // next write is a fresh command
        PH_ARG  = 2'd1,   // next write is the argument of the command
        PH_BUF  = 2'd2,   // buffered data words are being collected
        PH_CONF = 2'd3    // buffered write waits for its confirm code
    } phase_e;

    localparam logic [7:0] CMD_ARRAY  = 8'h00;
    localparam logic [7:0] CMD_PROG_A = 8'h10;
    localparam logic [7:0] CMD_ERASE  = 8'h20;
    localparam logic [7:0] CMD_PROG_B = 8'h40;
    localparam logic [7:0] CMD_CLEAR  = 8'h50;
    localparam logic [7:0] CMD_LOCK   = 8'h60;
    localparam logic [7:0] CMD_STATUS = 8'h70;
    localparam logic [7:0] CMD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_QUERY  = 8'h98;
    localparam logic [7:0] CMD_BUFWR  = 8'hE8;
    localparam logic [7:0] CMD_EXIT   = 8'hFF;
    localparam logic [7:0] ARG_GO     = 8'hD0;
    localparam logic [7:0] ARG_ALT    = 8'h01;

    localparam int ST_READY = 7;
    localparam int ST_EFAIL = 5;
    localparam int ST_PFAIL = 4;

endpackage

// File: rtl/pnor_seq.sv
// Command sequencer: decodes host command bytes, walks the multi-write
// phases and owns the status register. Assumes wr_en is a single-cycle
// strobe per bus write and that the read-only pin is static.
module pnor_seq
    import pnor_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wbyte,
    input  logic       ro_i,
    output logic [7:0] mode_q,
    output logic [7:0] status_q,
    output phase_e     phase_q,
    output logic       prog_en,
    output logic       erase_en
);

    logic [7:0] count_q;
    logic       is_prog;

    // Flags an armed single-word program.
    always_comb is_prog = (mode_q == CMD_PROG_A) || (mode_q == CMD_PROG_B);

    // Array strobes: store on program/buffer data writes, erase at setup.
    always_comb begin
        prog_en  = wr_en && !ro_i &&
                   (((phase_q == PH_ARG) && is_prog) || (phase_q == PH_BUF));
        erase_en = wr_en && !ro_i && (phase_q == PH_IDLE) && (wbyte == CMD_ERASE);
    end

    // Phase, mode, count and status updates on each host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            mode_q   <= CMD_ARRAY;
            status_q <= 8'h00;
            count_q  <= 8'h00;
        end else if (wr_en) begin
            unique case (phase_q)
                PH_IDLE: begin
                    case (wbyte)
                        CMD_PROG_A, CMD_PROG_B, CMD_LOCK, CMD_QUERY: begin
                            mode_q  <= wbyte;
                            phase_q <= PH_ARG;
                        end
                        CMD_ERASE: begin
                            mode_q  <= wbyte;
                            phase_q <= PH_ARG;
                            if (ro_i) status_q[ST_EFAIL] <= 1'b1;
                            status_q[ST_READY] <= 1'b1;
                        end
                        CMD_BUFWR: begin
                            mode_q  <= wbyte;
                            phase_q <= PH_ARG;
                            status_q[ST_READY] <= 1'b1;
                        end
                        CMD_CLEAR: begin
                            status_q <= 8'h00;
                            mode_q   <= CMD_ARRAY;
                        end
                        CMD_STATUS, CMD_IDENT: mode_q <= wbyte;
                        default:               mode_q <= CMD_ARRAY;
                    endcase
                end
                PH_ARG: begin
                    if (is_prog) begin
                        if (ro_i) status_q[ST_PFAIL] <= 1'b1;
                        status_q[ST_READY] <= 1'b1;
                        phase_q <= PH_IDLE;
                        mode_q  <= CMD_ARRAY;
                    end else if (mode_q == CMD_ERASE) begin
                        phase_q <= PH_IDLE;
                        if (wbyte == ARG_GO) status_q[ST_READY] <= 1'b1;
                        else                 mode_q <= CMD_ARRAY;
                    end else if (mode_q == CMD_LOCK) begin
                        phase_q <= PH_IDLE;
                        if (wbyte == ARG_GO || wbyte == ARG_ALT) status_q[ST_READY] <= 1'b1;
                        else                                     mode_q <= CMD_ARRAY;
                    end else if (mode_q == CMD_QUERY) begin
                        if (wbyte == CMD_EXIT) begin
                            phase_q <= PH_IDLE;
                            mode_q  <= CMD_ARRAY;
                        end
                    end else if (mode_q == CMD_BUFWR) begin
                        count_q <= wbyte;
                        phase_q <= PH_BUF;
                    end else begin
                        phase_q <= PH_IDLE;
                        mode_q  <= CMD_ARRAY;
                    end
                end
                PH_BUF: begin
                    if (ro_i) status_q[ST_PFAIL] <= 1'b1;
                    status_q[ST_READY] <= 1'b1;
                    if (count_q == 8'h00) phase_q <= PH_CONF;
                    count_q <= count_q - 8'd1;
                end
                PH_CONF: begin
                    phase_q <= PH_IDLE;
                    if (wbyte == ARG_GO) status_q[ST_READY] <= 1'b1;
                    else                 mode_q <= CMD_ARRAY;
                end
            endcase
        end
    end

endmodule

// File: rtl/pnor_array.sv
// Byte storage with a bus-wide word port. Words span consecutive byte
// addresses (wrapping at the top) in the order set by big_end. Erase fills
// the sector holding addr with 0xFF. Assumes power-of-two sizes and no reset
// of the contents.
module pnor_array #(
    parameter int BUS_BYTES  = 4,
    parameter int NUM_SECT   = 8,
    parameter int SECT_BYTES = 32,
    localparam int TOTAL     = NUM_SECT * SECT_BYTES,
    localparam int ADDR_W    = $clog2(TOTAL),
    localparam int SECT_SH   = $clog2(SECT_BYTES),
    localparam int BUS_W     = 8 * BUS_BYTES
) (
    input  logic              clk,
    input  logic              big_end,
    input  logic              prog_en,
    input  logic              erase_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rd_word
);

    logic [7:0] mem [TOTAL];
    logic [7:0] wr_lane [BUS_BYTES];

    for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
        // Byte k of the word: picks the data lane and the read byte by order.
        assign wr_lane[k] = big_end ? wdata[8*(BUS_BYTES-1-k) +: 8] : wdata[8*k +: 8];
        assign rd_word[8*k +: 8] = big_end ? mem[addr + ADDR_W'(BUS_BYTES-1-k)]
                                           : mem[addr + ADDR_W'(k)];
    end

    // Sector erase or word store into the byte array.
    always_ff @(posedge clk) begin
        if (erase_en) begin
            for (int i = 0; i < TOTAL; i++) begin
                if ((ADDR_W'(i) >> SECT_SH) == (addr >> SECT_SH)) mem[i] <= 8'hFF;
            end
        end
        if (prog_en) begin
            for (int k = 0; k < BUS_BYTES; k++) mem[addr + ADDR_W'(k)] <= wr_lane[k];
        end
    end

endmodule

// File: rtl/pnor_rdmux.sv
// Read path: chooses array word, status, identifier pair or query byte by
// the current mode and registers it one clock after the read strobe.
// Assumes the mode input is the sequencer's registered mode.
module pnor_rdmux
    import pnor_pkg::*;
#(
    parameter int          BUS_BYTES  = 4,
    parameter int          NUM_SECT   = 8,
    parameter int          SECT_BYTES = 32,
    parameter int          QRY_LEN    = 48,
    parameter logic [15:0] ID_W0      = 16'h00A1,
    parameter logic [15:0] ID_W1      = 16'h00B2,
    parameter logic [15:0] ID_W2      = 16'h0C3D,
    parameter logic [15:0] ID_W3      = 16'h4E5F,
    localparam int ADDR_W = $clog2(NUM_SECT * SECT_BYTES),
    localparam int BUS_W  = 8 * BUS_BYTES,
    localparam int IDX_SH = $clog2(BUS_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [7:0]        mode,
    input  logic [7:0]        status,
    input  logic [BUS_W-1:0]  arr_word,
    input  logic [ADDR_W-1:0] addr,
    output logic [BUS_W-1:0]  rdata_q
);

    logic [7:0]       idx;
    logic [BUS_W-1:0] rd_next;

    // Computed query table contents.
    function automatic logic [7:0] qry_byte(input logic [7:0] i);
        case (i)
            8'h10:   return 8'h51;
            8'h11:   return 8'h52;
            8'h12:   return 8'h59;
            8'h13:   return 8'h01;
            8'h27:   return 8'(ADDR_W);
            8'h2C:   return 8'h01;
            8'h2D:   return 8'(NUM_SECT - 1);
            default: return 8'h00;
        endcase
    endfunction

    // Word index from the low address byte, scaled by the bus width.
    always_comb idx = 8'(addr) >> IDX_SH;

    // Mode-dependent read value.
    always_comb begin
        case (mode)
            CMD_ARRAY: rd_next = arr_word;
            CMD_IDENT: begin
                if (idx == 8'd0)      rd_next = BUS_W'({ID_W0, ID_W1});
                else if (idx == 8'd1) rd_next = BUS_W'({ID_W2, ID_W3});
                else                  rd_next = '0;
            end
            CMD_QUERY: rd_next = (int'(idx) < QRY_LEN) ? BUS_W'(qry_byte(idx)) : '0;
            default:   rd_next = BUS_W'(status);
        endcase
    end

    // Read result register, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_next;
    end

endmodule

// File: rtl/pnor_cmd_if.sv
// Top level of the parallel NOR command front end: sequencer, byte array
// and read path. Assumes wr_en_i and rd_en_i are never high together and that
// big_end_i and wr_prot_i are static.
module pnor_cmd_if
    import pnor_pkg::*;
#(
    parameter int          BUS_BYTES  = 4,
    parameter int          NUM_SECT   = 8,
    parameter int          SECT_BYTES = 32,
    parameter int          QRY_LEN    = 48,
    parameter logic [15:0] ID_W0      = 16'h00A1,
    parameter logic [15:0] ID_W1      = 16'h00B2,
    parameter logic [15:0] ID_W2      = 16'h0C3D,
    parameter logic [15:0] ID_W3      = 16'h4E5F
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   big_end_i,
    input  logic                                   wr_prot_i,
    input  logic [$clog2(NUM_SECT*SECT_BYTES)-1:0] addr_i,
    input  logic [8*BUS_BYTES-1:0]                 wdata_i,
    input  logic                                   wr_en_i,
    input  logic                                   rd_en_i,
    output logic [8*BUS_BYTES-1:0]                 rdata_o
);

    localparam int BUS_W = 8 * BUS_BYTES;

    logic [7:0]       mode_w;
    logic [7:0]       status_w;
    phase_e           phase_w;
    logic             prog_en_w;
    logic             erase_en_w;
    logic [BUS_W-1:0] arr_word_w;

    pnor_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en_i),
        .wbyte    (wdata_i[7:0]),
        .ro_i     (wr_prot_i),
        .mode_q   (mode_w),
        .status_q (status_w),
        .phase_q  (phase_w),
        .prog_en  (prog_en_w),
        .erase_en (erase_en_w)
    );

    pnor_array #(
        .BUS_BYTES  (BUS_BYTES),
        .NUM_SECT   (NUM_SECT),
        .SECT_BYTES (SECT_BYTES)
    ) u_array (
        .clk      (clk),
        .big_end  (big_end_i),
        .prog_en  (prog_en_w),
        .erase_en (erase_en_w),
        .addr     (addr_i),
        .wdata    (wdata_i),
        .rd_word  (arr_word_w)
    );

    pnor_rdmux #(
        .BUS_BYTES  (BUS_BYTES),
        .NUM_SECT   (NUM_SECT),
        .SECT_BYTES (SECT_BYTES),
        .QRY_LEN    (QRY_LEN),
        .ID_W0      (ID_W0),
        .ID_W1      (ID_W1),
        .ID_W2      (ID_W2),
        .ID_W3      (ID_W3)
    ) u_rdmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en_i),
        .mode     (mode_w),
        .status   (status_w),
        .arr_word (arr_word_w),
        .addr     (addr_i),
        .rdata_q  (rdata_o)
    );

endmodule

// File: rtl/pnor_cmd_if_chk.sv
// Property checker for pnor_cmd_if, attached by bind below. Watches the
// strobes, the sequencer state, the array word and the registered read data.
module pnor_cmd_if_chk
    import pnor_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [7:0]       wbyte,
    input logic             ro,
    input logic [7:0]       mode,
    input logic [7:0]       status,
    input phase_e           phase,
    input logic             prog_en,
    input logic             erase_en,
    input logic [BUS_W-1:0] arr_word,
    input logic [BUS_W-1:0] rdata
);

    p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));

    p_rd_array_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode == CMD_ARRAY) |=> (rdata == $past(arr_word)));

    p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    p_ro_nostore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ro |-> (!prog_en && !erase_en));

    p_prog_fail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ro && phase == PH_ARG && (mode == CMD_PROG_A || mode == CMD_PROG_B))
        |=> (status[ST_PFAIL] && status[ST_READY]));

    p_erase_fail_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ro && phase == PH_IDLE && wbyte == CMD_ERASE) |=> status[ST_EFAIL]);

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && phase == PH_IDLE && wbyte == CMD_CLEAR)
        |=> (status == 8'h00 && mode == CMD_ARRAY));

    p_status_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode == CMD_STATUS) |=> (rdata == BUS_W'($past(status))));

    p_conf_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CONF) |-> (mode == CMD_BUFWR));

endmodule

bind pnor_cmd_if pnor_cmd_if_chk #(.BUS_W(8 * BUS_BYTES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en_i),
    .rd_en    (rd_en_i),
    .wbyte    (wdata_i[7:0]),
    .ro       (wr_prot_i),
    .mode     (mode_w),
    .status   (status_w),
    .phase    (phase_w),
    .prog_en  (prog_en_w),
    .erase_en (erase_en_w),
    .arr_word (arr_word_w),
    .rdata    (rdata_o)
);

// File: tb/pnor_cmd_if_tb_top.sv
`timescale 1ns/1ps
// Bench for pnor_cmd_if with default parameters (4-byte bus, 256-byte array).
module pnor_cmd_if_tb_top;

    typedef struct packed {
        logic        rd;    // 1: read and compare, 0: write
        logic [7:0]  a;
        logic [31:0] d;     // write data or expected read data
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 66;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 32'h0000_00FF, 4'd1},   // R1 array mode
        '{1'b0, 8'h20, 32'h0000_0020, 4'd3},   // R3 erase sector 1
        '{1'b1, 8'h20, 32'h0000_0080, 4'd5},   // R5 pending erase reads status
        '{1'b0, 8'h20, 32'h0000_00D0, 4'd4},   // R4 confirm
        '{1'b1, 8'h24, 32'h0000_0080, 4'd4},
        '{1'b0, 8'h00, 32'h0000_00FF, 4'd1},
        '{1'b1, 8'h24, 32'hFFFF_FFFF, 4'd3},
        '{1'b1, 8'h3C, 32'hFFFF_FFFF, 4'd3},
        '{1'b0, 8'h24, 32'h0000_0040, 4'd2},   // R2 program
        '{1'b0, 8'h24, 32'h1122_3344, 4'd2},
        '{1'b1, 8'h24, 32'h1122_3344, 4'd2},
        '{1'b1, 8'h25, 32'hFF11_2233, 4'd10},  // R10 unaligned little-endian
        '{1'b0, 8'h00, 32'h0000_0070, 4'd5},
        '{1'b1, 8'h00, 32'h0000_0080, 4'd5},
        '{1'b0, 8'h00, 32'h0000_0050, 4'd5},   // clear status
        '{1'b1, 8'h24, 32'h1122_3344, 4'd5},
        '{1'b0, 8'h00, 32'h0000_0070, 4'd5},
        '{1'b1, 8'h00, 32'h0000_0000, 4'd5},
        '{1'b0, 8'h00, 32'h0000_0090, 4'd6},   // R6 identifier
        '{1'b1, 8'h00, 32'h00A1_00B2, 4'd6},
        '{1'b1, 8'h04, 32'h0C3D_4E5F, 4'd6},
        '{1'b1, 8'h08, 32'h0000_0000, 4'd6},
        '{1'b0, 8'h00, 32'h0000_0098, 4'd7},   // R7 query
        '{1'b1, 8'h40, 32'h0000_0051, 4'd7},
        '{1'b1, 8'h44, 32'h0000_0052, 4'd7},
        '{1'b1, 8'h9C, 32'h0000_0008, 4'd7},
        '{1'b1, 8'hC0, 32'h0000_0000, 4'd7},
        '{1'b0, 8'h00, 32'h0000_0012, 4'd7},
        '{1'b1, 8'h48, 32'h0000_0059, 4'd7},
        '{1'b0, 8'h00, 32'h0000_00FF, 4'd7},
        '{1'b1, 8'h24, 32'h1122_3344, 4'd7},
        '{1'b0, 8'h28, 32'h0000_00E8, 4'd8},   // R8 buffered write, N=1
        '{1'b0, 8'h00, 32'h0000_0001, 4'd8},
        '{1'b0, 8'h28, 32'hAABB_CCDD, 4'd8},
        '{1'b1, 8'h00, 32'h0000_0080, 4'd8},
        '{1'b0, 8'h2C, 32'h0102_0304, 4'd8},
        '{1'b0, 8'h00, 32'h0000_00D0, 4'd8},
        '{1'b1, 8'h00, 32'h0000_0080, 4'd8},
        '{1'b0, 8'h00, 32'h0000_00FF, 4'd1},
        '{1'b1, 8'h28, 32'hAABB_CCDD, 4'd8},
        '{1'b1, 8'h2C, 32'h0102_0304, 4'd8},
        '{1'b0, 8'h30, 32'h0000_00E8, 4'd8},   // buffered write aborted at confirm
        '{1'b0, 8'h00, 32'h0000_0000, 4'd8},
        '{1'b0, 8'h30, 32'h5566_7788, 4'd8},
        '{1'b0, 8'h00, 32'h0000_0033, 4'd8},
        '{1'b1, 8'h30, 32'h5566_7788, 4'd8},
        '{1'b0, 8'h00, 32'h0000_0060, 4'd9},   // R9 lock
        '{1'b1, 8'h00, 32'h0000_0080, 4'd9},
        '{1'b0, 8'h00, 32'h0000_0001, 4'd9},
        '{1'b1, 8'h00, 32'h0000_0080, 4'd9},
        '{1'b0, 8'h00, 32'h0000_0060, 4'd9},
        '{1'b0, 8'h00, 32'h0000_0077, 4'd9},
        '{1'b1, 8'h28, 32'hAABB_CCDD, 4'd9},
        '{1'b0, 8'h00, 32'h0000_0090, 4'd1},   // unknown code leaves ident mode
        '{1'b0, 8'h00, 32'h0000_0033, 4'd1},
        '{1'b1, 8'h28, 32'hAABB_CCDD, 4'd1},
        '{1'b0, 8'h00, 32'h0000_0090, 4'd1},
        '{1'b0, 8'h00, 32'h0000_00F0, 4'd1},
        '{1'b1, 8'h28, 32'hAABB_CCDD, 4'd1},
        '{1'b0, 8'h40, 32'h0000_0020, 4'd4},   // erase then bad confirm
        '{1'b0, 8'h00, 32'h0000_0055, 4'd4},
        '{1'b1, 8'h40, 32'hFFFF_FFFF, 4'd4},
        '{1'b0, 8'h44, 32'h0000_0020, 4'd4},
        '{1'b0, 8'h00, 32'h0000_00FF, 4'd4},
        '{1'b1, 8'h5C, 32'hFFFF_FFFF, 4'd3},
        '{1'b1, 8'h30, 32'h5566_7788, 4'd3}    // neighbour sector untouched
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_end_i = 1'b0;
    logic        wr_prot_i = 1'b0;
    logic [7:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic        wr_en_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [31:0] rdata_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pnor_cmd_if dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .big_end_i (big_end_i),
        .wr_prot_i (wr_prot_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .wr_en_i   (wr_en_i),
        .rd_en_i   (rd_en_i),
        .rdata_o   (rdata_o)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h exp %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        addr_i = a; rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
        chk(req, rdata_o, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R12: watchdog expired, got hang exp completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state of read output and status
        chk("R11", rdata_o, 32'h0);
        wr(8'h00, 32'h70);
        rd(8'h00, 32'h0, "R11");

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) rd(VECS[i].a, VECS[i].d, $sformatf("R%0d", VECS[i].req));
            else            wr(VECS[i].a, VECS[i].d);
        end

        // R10: big-endian read and write
        big_end_i = 1'b1;
        rd(8'h28, 32'hDDCC_BBAA, "R10");
        wr(8'h48, 32'h40);
        wr(8'h48, 32'h1234_5678);
        big_end_i = 1'b0;
        rd(8'h48, 32'h7856_3412, "R10");

        // R2: read-only program sets bit 4, leaves array
        wr_prot_i = 1'b1;
        wr(8'h00, 32'h50);
        wr(8'h48, 32'h40);
        wr(8'h48, 32'h0);
        wr(8'h00, 32'h70);
        rd(8'h00, 32'h90, "R2");
        wr(8'h00, 32'hFF);
        rd(8'h48, 32'h7856_3412, "R2");

        // R3: read-only erase sets bit 5, leaves sector
        wr(8'h00, 32'h50);
        wr(8'h40, 32'h20);
        rd(8'h00, 32'hA0, "R3");
        wr(8'h00, 32'hD0);
        wr(8'h00, 32'hFF);
        rd(8'h48, 32'h7856_3412, "R3");

        // R8: read-only buffered write
        wr(8'h00, 32'h50);
        wr(8'h50, 32'hE8);
        wr(8'h00, 32'h0);
        wr(8'h50, 32'h9999_9999);
        wr(8'h00, 32'hD0);
        rd(8'h00, 32'h90, "R8");
        wr(8'h00, 32'hFF);
        rd(8'h50, 32'hFFFF_FFFF, "R8");
        wr_prot_i = 1'b0;

        // R12: output holds between reads, a write leaves it alone
        rd(8'h28, 32'hAABB_CCDD, "R12");
        repeat (3) @(negedge clk);
        chk("R12", rdata_o, 32'hAABB_CCDD);
        wr(8'h00, 32'h70);
        chk("R12", rdata_o, 32'hAABB_CCDD);

        // R11: reset during query mode returns to array mode, keeps array
        wr(8'h00, 32'hFF);
        wr(8'h00, 32'h98);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R11", rdata_o, 32'h0);
        rd(8'h28, 32'hAABB_CCDD, "R11");
        wr(8'h00, 32'h70);
        rd(8'h00, 32'h0, "R11");

        finish_run();
    end

endmodule